// File: doc/BRIEF.md
# Converter Parallel Register Port Model

This block is a synthesizable device-side model of a data converter's parallel register port. A host controller under test drives it through active-low chip select, read and write strobes, a byte-select line and a 12-bit data bus. The model answers the way the real converter would. Reads are level-gated and return either the low 12 bits or the high 8 bits of a 16-bit register word. Writes are taken one byte at a time and put together into 16-bit command words. A conversion-start input raises a busy flag for a fixed number of cycles.

Every signal, including the host strobes, is sampled on the model's own clock. The data bus is given as a value and an output enable, and the tri-state buffer sits at the chip pads. No analog front end is modelled. Each finished conversion adds a fixed step to a 12-bit stimulus counter, and that counter serves as the conversion result. The result counter is updated a set number of cycles before busy falls. A host that holds chip select and read low all the time therefore sees the new data on the bus before busy falls, and can capture it on that falling edge.

Top module: `adc_pport_model`

## Requirements
- R1: After reset, busy is low, the bus is released (output enable low, data zero), the result is zero, and a low-byte read returns 0x000.
- R2: The output enable is high in exactly the cycles where chip select and read are both low. It follows those inputs with no clock delay. Holding both low keeps the bus driven through a whole conversion.
- R3: A read with byte-select low drives bits 11:0 of the selected 16-bit word. A read with byte-select high drives bits 15:8 of that word on lines 7:0, and lines 11:8 are zero.
- R4: A write is the span of cycles in which chip select and write are both low. Data and byte-select from the last cycle of that span take effect at the first clock edge after the strobe is released. A low-byte write (byte-select low) only loads bits 7:0 into a holding byte. Bus lines 11:8 are ignored on every write.
- R5: A high-byte write commits the word {data[7:0], holding byte}. Bits 15:14 of that word select the target: 01 is the test register, 10 is the control register, 11 is the calibration register, and 00 changes nothing. Bits 13:0 become the register's payload.
- R6: The test register payload resets to 0x0002. Writing the word 0x4002 as two byte writes restores that value.
- R7: Control payload bits 2:1 choose the read source: 00 is the result, 01 is test, 10 is control, 11 is calibration. The read word of a register is {its two-bit code, payload}, and the result word is {4'b0000, result}. Control bit 0 starts a conversion when written as 1 and always reads back as 0.
- R8: A rising edge on the conversion-start input while idle sets busy at the next clock edge. Busy then stays high for exactly CONV_CYCLES cycles. A start request while busy is ignored.
- R9: Each conversion adds RESULT_STEP (mod 4096) to the result. The new value is visible on the bus LEAD_CYCLES cycles before busy falls.
- R10: Write strobes given while chip select is high change neither the registers nor the holding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hbyte | input | 1 | Byte select: 0 low part, 1 high byte |
| conv_start | input | 1 | Conversion start, acts on rising edge |
| db_in | input | 12 | Data bus value driven by the host |
| db_out | output | 12 | Data bus value driven by the model |
| db_oe | output | 1 | Data bus output enable |
| busy | output | 1 | Conversion in progress |

## Verification
Read data and output enable are combinational from the strobes, so the bench samples them 1 ns after it drives the strobes at a falling clock edge. A write commits at the first rising edge after the strobe is released, so the bench waits one more falling edge before it reads back. Busy rises at the edge that sees the start edge, and the result changes CONV_CYCLES minus LEAD_CYCLES edges after that. With the bus held in continuous read, the bench counts falling edges from the start and checks the exact count at which busy was seen and at which the new result first appeared.

// File: rtl/adc_pport_pkg.sv
package adc_pport_pkg;
  localparam int unsigned BUS_W  = 12;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned PAY_W  = WORD_W - 2;
  localparam int unsigned RES_W  = BUS_W;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'b00,
    RSEL_TEST = 2'b01,
    RSEL_CTRL = 2'b10,
    RSEL_CAL  = 2'b11
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e              sel;
    logic [PAY_W-1:0]      payload;
  } cmd_word_t;

  localparam logic [PAY_W-1:0] TEST_DEFAULT   = PAY_W'(2);
  localparam int unsigned      CTRL_START_BIT = 0;
  localparam int unsigned      CTRL_RSEL_LSB  = 1;
endpackage

// File: rtl/adc_pport_wr_asm.sv
module adc_pport_wr_asm
  import adc_pport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             hbyte,
  input  logic [BUS_W-1:0] db_in,
  output logic             commit_valid,
  output cmd_word_t        commit_word
);
  logic              wr_act;
  logic              wr_act_q;
  logic              release_edge;
  logic              hb_d, hb_q;
  logic [BYTE_W-1:0] byte_d, byte_q;
  logic [BYTE_W-1:0] hold_d, hold_q;
  logic              wr_hi_unused;

  assign wr_act       = ~cs_n & ~wr_n;
  assign release_edge = wr_act_q & ~wr_act;
  assign wr_hi_unused = ^db_in[BUS_W-1:BYTE_W];

  always_comb begin
    byte_d = byte_q;
    hb_d   = hb_q;
    hold_d = hold_q;
    if (wr_act) begin
      byte_d = db_in[BYTE_W-1:0];
      hb_d   = hbyte;
    end
    if (release_edge && !hb_q) begin
      hold_d = byte_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      hb_q     <= 1'b0;
      byte_q   <= '0;
      hold_q   <= '0;
    end else begin
      wr_act_q <= wr_act;
      hb_q     <= hb_d;
      byte_q   <= byte_d;
      hold_q   <= hold_d;
    end
  end

  assign commit_valid = release_edge & hb_q;
  assign commit_word  = cmd_word_t'({byte_q, hold_q});

  // R5: a commit only follows a cycle in which the gated strobe was active
  assert_commit_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(~cs_n & ~wr_n));

  // R10: holding byte moves only after a released chip-selected strobe
  assert_hold_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_q) |-> $past(~cs_n & ~wr_n, 2));
endmodule

// File: rtl/adc_pport_regfile.sv
module adc_pport_regfile
  import adc_pport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_valid,
  input  cmd_word_t        commit_word,
  output logic [PAY_W-1:0] test_q,
  output logic [PAY_W-1:0] ctrl_q,
  output logic [PAY_W-1:0] cal_q,
  output logic             sw_start
);
  logic [PAY_W-1:0] test_d, ctrl_d, cal_d;
  logic             en_test, en_ctrl, en_cal;

  assign en_test = commit_valid && (commit_word.sel == RSEL_TEST);
  assign en_ctrl = commit_valid && (commit_word.sel == RSEL_CTRL);
  assign en_cal  = commit_valid && (commit_word.sel == RSEL_CAL);

  always_comb begin
    test_d = test_q;
    ctrl_d = ctrl_q;
    cal_d  = cal_q;
    if (en_test) test_d = commit_word.payload;
    if (en_ctrl) begin
      ctrl_d                 = commit_word.payload;
      ctrl_d[CTRL_START_BIT] = 1'b0;
    end
    if (en_cal) cal_d = commit_word.payload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= TEST_DEFAULT;
      ctrl_q <= '0;
      cal_q  <= '0;
    end else begin
      test_q <= test_d;
      ctrl_q <= ctrl_d;
      cal_q  <= cal_d;
    end
  end

  assign sw_start = en_ctrl && commit_word.payload[CTRL_START_BIT];

  // R5: test payload changes only through a commit addressed to it
  assert_test_only_by_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(test_q) |-> $past(commit_valid && commit_word.sel == RSEL_TEST));

  // R5: calibration payload changes only through a commit addressed to it
  assert_cal_only_by_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_q) |-> $past(commit_valid && commit_word.sel == RSEL_CAL));
endmodule

// File: rtl/adc_pport_conv.sv
module adc_pport_conv
  import adc_pport_pkg::*;
#(
  parameter int unsigned     CONV_CYCLES = 16,
  parameter int unsigned     LEAD_CYCLES = 2,
  parameter logic [RES_W-1:0] RESULT_STEP = 12'h123
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             sw_start,
  output logic             busy,
  output logic [RES_W-1:0] result
);
  localparam int unsigned CNT_W   = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam int unsigned LAST    = CONV_CYCLES - 1;
  localparam int unsigned LOAD_AT = CONV_CYCLES - 1 - LEAD_CYCLES;

  logic             start_q;
  logic             start_req;
  logic             busy_d, busy_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic [RES_W-1:0] res_d, res_q;

  assign start_req = (conv_start & ~start_q) | sw_start;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    res_d  = res_q;
    if (!busy_q) begin
      if (start_req) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(LOAD_AT)) res_d = res_q + RESULT_STEP;
      if (cnt_q == CNT_W'(LAST)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      res_q   <= '0;
    end else begin
      start_q <= conv_start;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      res_q   <= res_d;
    end
  end

  assign busy   = busy_q;
  assign result = res_q;

  // R8: an idle start request raises busy at the next edge
  assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy_q) |=> busy_q);

  // R8: busy never rises without a start request
  assert_busy_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_req));

  // R9: result changes only inside a conversion, with busy still high afterwards
  assert_result_before_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> (busy_q && $past(busy_q)));
endmodule

// File: rtl/adc_pport_rd_mux.sv
module adc_pport_rd_mux
  import adc_pport_pkg::*;
(
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hbyte,
  input  logic [1:0]       rsel,
  input  logic [RES_W-1:0] result,
  input  logic [PAY_W-1:0] test_q,
  input  logic [PAY_W-1:0] ctrl_q,
  input  logic [PAY_W-1:0] cal_q,
  output logic [BUS_W-1:0] db_out,
  output logic             db_oe
);
  logic [WORD_W-1:0] word;

  always_comb begin
    unique case (reg_sel_e'(rsel))
      RSEL_TEST: word = {RSEL_TEST, test_q};
      RSEL_CTRL: word = {RSEL_CTRL, ctrl_q};
      RSEL_CAL:  word = {RSEL_CAL, cal_q};
      default:   word = {{(WORD_W-RES_W){1'b0}}, result};
    endcase
  end

  assign db_oe = ~cs_n & ~rd_n;

  always_comb begin
    db_out = '0;
    if (db_oe) begin
      if (hbyte) db_out = {{(BUS_W-BYTE_W){1'b0}}, word[WORD_W-1:BYTE_W]};
      else       db_out = word[BUS_W-1:0];
    end
  end
endmodule

// File: rtl/adc_pport_model.sv
module adc_pport_model
  import adc_pport_pkg::*;
#(
  parameter int unsigned      CONV_CYCLES = 16,
  parameter int unsigned      LEAD_CYCLES = 2,
  parameter logic [RES_W-1:0] RESULT_STEP = 12'h123
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             hbyte,
  input  logic             conv_start,
  input  logic [BUS_W-1:0] db_in,
  output logic [BUS_W-1:0] db_out,
  output logic             db_oe,
  output logic             busy
);
  logic             rst_s1, rst_s2, rst_core_n;
  logic             commit_valid;
  cmd_word_t        commit_word;
  logic [PAY_W-1:0] test_q, ctrl_q, cal_q;
  logic             sw_start;
  logic [RES_W-1:0] result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_core_n = rst_s2;

  adc_pport_wr_asm u_wr (
    .clk, .rst_n(rst_core_n), .cs_n, .wr_n, .hbyte, .db_in,
    .commit_valid, .commit_word
  );

  adc_pport_regfile u_regs (
    .clk, .rst_n(rst_core_n), .commit_valid, .commit_word,
    .test_q, .ctrl_q, .cal_q, .sw_start
  );

  adc_pport_conv #(
    .CONV_CYCLES(CONV_CYCLES), .LEAD_CYCLES(LEAD_CYCLES), .RESULT_STEP(RESULT_STEP)
  ) u_conv (
    .clk, .rst_n(rst_core_n), .conv_start, .sw_start, .busy, .result
  );

  adc_pport_rd_mux u_rd (
    .cs_n, .rd_n, .hbyte, .rsel(ctrl_q[CTRL_RSEL_LSB +: 2]),
    .result, .test_q, .ctrl_q, .cal_q, .db_out, .db_oe
  );

  // R3: a high-byte read leaves lines 11:8 at zero
  assert_hi_read_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (db_oe && hbyte) |-> (db_out[BUS_W-1:BYTE_W] == '0));

  // R2: a released bus carries no data
  assert_released_bus_quiet_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !db_oe |-> (db_out == '0));
endmodule

// File: tb/adc_pport_model_tb.sv
module adc_pport_model_tb;
  localparam int unsigned CONV  = 16;
  localparam int unsigned LEAD  = 2;
  localparam logic [11:0] STEP  = 12'h123;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_n, wr_n, hbyte, conv_start;
  logic [11:0] db_in;
  logic [11:0] db_out;
  logic        db_oe, busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [13:0] test_m, ctrl_m, cal_m;
  logic [11:0] res_m;

  always #5 clk = ~clk;

  adc_pport_model #(.CONV_CYCLES(CONV), .LEAD_CYCLES(LEAD), .RESULT_STEP(STEP)) u_dut (
    .clk, .rst_n, .cs_n, .rd_n, .wr_n, .hbyte, .conv_start, .db_in,
    .db_out, .db_oe, .busy
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    case (ctrl_m[2:1])
      2'b01:   return {2'b01, test_m};
      2'b10:   return {2'b10, ctrl_m};
      2'b11:   return {2'b11, cal_m};
      default: return {4'h0, res_m};
    endcase
  endfunction

  task automatic wr_byte(input bit hb, input logic [11:0] d, input bit sel);
    @(negedge clk);
    cs_n = ~sel; wr_n = 1'b0; hbyte = hb; db_in = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; db_in = 12'($urandom);
    @(negedge clk);
  endtask

  task automatic apply_word(input logic [15:0] w);
    case (w[15:14])
      2'b01: test_m = w[13:0];
      2'b10: ctrl_m = w[13:0] & ~14'h1;
      2'b11: cal_m  = w[13:0];
      default: ;
    endcase
  endtask

  task automatic write_word(input logic [15:0] w);
    wr_byte(1'b0, {4'($urandom), w[7:0]}, 1'b1);
    wr_byte(1'b1, {4'($urandom), w[15:8]}, 1'b1);
    apply_word(w);
  endtask

  task automatic rd(input bit hb, output logic [11:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hbyte = hb;
    #1;
    d = db_out; oe = db_oe;
    #1;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic check_reads(input string req);
    logic [11:0] d;
    logic        oe;
    logic [15:0] w;
    w = exp_word();
    rd(1'b0, d, oe);
    check(req, {20'h0, d}, {20'h0, w[11:0]});
    check("R2", {31'h0, oe}, 32'h1);
    rd(1'b1, d, oe);
    check({req, " R3"}, {20'h0, d}, {24'h0, w[15:8]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] d;
    logic        oe;
    logic [15:0] w;
    int          busy_cnt;
    int          k_new;
    bit          oe_ok;
    void'($urandom(32'h5eed_0042));
    test_m = 14'h0002; ctrl_m = '0; cal_m = '0; res_m = '0;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; hbyte = 1'b0;
    conv_start = 1'b0; db_in = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy in reset", {31'h0, busy}, 32'h0);
    check("R1 oe in reset", {31'h0, db_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 bus released", {19'h0, db_oe, db_out}, 32'h0);
    rd(1'b0, d, oe);
    check("R1 result read", {20'h0, d}, 32'h0);

    // R2: only both strobes low enable the bus
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    check("R2 rd without cs", {31'h0, db_oe}, 32'h0);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    check("R2 cs without rd", {31'h0, db_oe}, 32'h0);
    cs_n = 1'b1;

    // R6: test register default, read via select 01 (R7)
    write_word(16'h8002);
    check_reads("R6 default");
    write_word(16'h5ABC);
    check_reads("R5 test write");
    write_word(16'h4002);
    check_reads("R6 restore");

    // R4: lone low byte only loads the holding byte
    wr_byte(1'b0, 12'hF55, 1'b1);
    check_reads("R4 lone low byte");
    wr_byte(1'b1, 12'hA7F, 1'b1);
    apply_word(16'h7F55);
    check_reads("R4 holding byte commit");

    // R10: strobes without chip select are ignored
    wr_byte(1'b0, 12'h011, 1'b0);
    wr_byte(1'b1, 12'h040, 1'b0);
    check_reads("R10 no cs write");
    wr_byte(1'b1, 12'h041, 1'b1);
    apply_word(16'h4155);
    check_reads("R10 hold intact");

    // R5: address 00 changes nothing
    write_word(16'h1234);
    check_reads("R5 null target");

    // R5/R7: random words
    for (int i = 0; i < 24; i++) begin
      w = 16'($urandom);
      if (w[15:14] == 2'b10) w[0] = 1'b0;
      write_word(w);
      check_reads("R5 random");
    end

    // R8/R9: hardware start with bus held in continuous read
    write_word(16'h8000);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hbyte = 1'b0; conv_start = 1'b1;
    busy_cnt = 0; k_new = -1; oe_ok = 1'b1;
    for (int k = 0; k < int'(CONV) + 3; k++) begin
      @(negedge clk);
      conv_start = (k == 3);
      #1;
      if (busy) busy_cnt++;
      if (!db_oe) oe_ok = 1'b0;
      if (k_new < 0 && db_out == res_m + STEP) k_new = k;
    end
    check("R8 busy length", busy_cnt, CONV);
    check("R9 data lead", k_new, CONV - LEAD);
    check("R9 one step only", {20'h0, db_out}, {20'h0, res_m + STEP});
    check("R2 tied-low drive", {31'h0, oe_ok}, 32'h1);
    res_m = res_m + STEP;
    cs_n = 1'b1; rd_n = 1'b1; conv_start = 1'b0;

    // R7: control bit 0 starts a conversion and reads back as 0
    write_word(16'h8005);
    #1;
    check("R7 sw start busy", {31'h0, busy}, 32'h1);
    for (int n = 0; n < 100 && busy; n++) @(negedge clk);
    res_m = res_m + STEP;
    check_reads("R7 control readback");
    write_word(16'h8000);
    check_reads("R9 sw result");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule